// File: doc/BRIEF.md
# Descriptor-chained DMA channel sequencer

This block is the control engine of one DMA channel. Software loads four setup words while the channel is idle: a source address, a destination address, a pointer to the next descriptor and a control word. It then pulses a start input. The channel copies 32-bit words, one at a time, through a single request/response memory port. Before every word it raises a pending request and waits until both the priority grant and the bus-mastership grant are present. The destination can be paced by a peripheral request line. When that option is on, each destination write waits for the request line. When a descriptor's count runs out, the destination gets a one-cycle acknowledge.

At terminal count the channel can raise a maskable interrupt pulse. If the next pointer is nonzero, the channel then reads a new four-word descriptor from memory and carries on. If the pointer is zero, the channel drops its enable and stops. An error response on any access raises an error pulse and stops the channel straight away. Software polls the enable output to learn when the chain has finished.

The memory port follows valid/ready rules on its request side. Once `mem_req_valid` is high, the address, direction and write data stay unchanged until a cycle with `mem_req_ready` high. Only one request is outstanding at a time. Responses have no back-pressure: the channel always accepts the single `mem_rsp_valid` cycle that answers its request.

Top module: `dma_chain_seq`

## Requirements
- R1: Setup words are selected by `cfg_sel`: 0 source, 1 destination, 2 next pointer, 3 control. In the control word, bits 11:0 are the word count, bit 31 enables the terminal-count interrupt and bit 30 selects a peripheral-paced destination. A `cfg_start` pulse while idle sets `ch_enabled` on the next cycle. Setup writes and start pulses that arrive while `ch_enabled` is high have no effect.
- R2: For every word, the source read is issued only after a cycle in which `prio_req`, `prio_grant` and `bus_grant` are all high.
- R3: Each word is read from the source address and written with the same data to the destination address. Both addresses then step by 4 and the count drops by one. A count of zero moves no word.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and data stay the same in the next cycle.
- R5: With bit 30 set, a destination write is requested only after `dst_req` has been seen high since the previous write. `dst_ack` pulses once for each descriptor that completes.
- R6: When the count reaches zero, `tc_irq` pulses for one cycle if bit 31 is set. It does not pulse if bit 31 is clear.
- R7: If the next pointer is nonzero at terminal count, the channel reads four words at the pointer plus 0, 4, 8 and 12. These load source, destination, next pointer and control in that order, and the transfer then resumes.
- R8: If the next pointer is zero at terminal count, `ch_enabled` falls and no further memory request is made.
- R9: An error response on a data read, data write or descriptor read makes `err_irq` pulse once. `ch_enabled` then falls, no terminal count is signalled for that descriptor, and no further request is made.
- R10: `tc_irq` and `err_irq` are each high for single cycles only and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_sel | input | 2 | Setup word select (0 src, 1 dst, 2 next, 3 ctrl) |
| cfg_wdata | input | 32 | Setup word value |
| cfg_start | input | 1 | Start pulse |
| ch_enabled | output | 1 | Channel enabled (busy) flag |
| prio_req | output | 1 | Channel wants the bus for its next word |
| prio_grant | input | 1 | Channel holds the highest pending priority |
| bus_grant | input | 1 | Bus mastership granted |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response valid, one cycle per request |
| mem_rsp_rdata | input | 32 | Read data |
| mem_rsp_err | input | 1 | Response carries an error |
| dst_req | input | 1 | Destination peripheral ready for a word |
| dst_ack | output | 1 | Descriptor complete, to destination peripheral |
| tc_irq | output | 1 | Terminal-count interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
Most internal faults show up in memory contents within one word. A wrong address step or a stale hold register leaves a wrong or missing destination word. A count that is off by one writes one word too many or too few past the end of a descriptor region. A mis-ordered descriptor load sends the next descriptor's data to the wrong place or stops the chain early. These effects are visible once the run ends. Faults in sequencing appear at once at the ports. These include a read issued without both grants, a paced write issued without a request, and a request that changes while stalled. Interrupt faults appear as wrong pulse counts at the end of the run.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ARB, S_RD_REQ, S_RD_RSP, S_WR_WAIT,
    S_WR_REQ, S_WR_RSP, S_TERM, S_FT_REQ, S_FT_RSP
  } seq_state_e;

  localparam int N_FIELDS   = 4;
  localparam int F_SRC      = 0;
  localparam int F_DST      = 1;
  localparam int F_NXT      = 2;
  localparam int F_CTL      = 3;
  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_chain_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          adv,
  output logic [DW-1:0] src_addr,
  output logic [DW-1:0] dst_addr,
  output logic [DW-1:0] nxt_ptr,
  output logic [CW-1:0] remain,
  output logic          tc_ie,
  output logic          to_periph
);

  logic [DW-1:0] fld [N_FIELDS];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && wr_sel == 2'(g)) begin
        q <= wr_data;
      end else if (adv) begin
        if (g == F_SRC || g == F_DST) begin
          q <= q + DW'(WORD_BYTES);
        end else if (g == F_CTL) begin
          q <= {q[DW-1:CW], q[CW-1:0] - CW'(1)};
        end
      end
    end
    assign fld[g] = q;
  end

  assign src_addr  = fld[F_SRC];
  assign dst_addr  = fld[F_DST];
  assign nxt_ptr   = fld[F_NXT];
  assign remain    = fld[F_CTL][CW-1:0];
  assign tc_ie     = fld[F_CTL][DW-1];
  assign to_periph = fld[F_CTL][DW-2];

  // R3: one step lowers the count by exactly one
  a_r3_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> remain == $past(remain) - CW'(1));

  // R1: a load never coincides with an address step
  a_r1_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && adv));

endmodule

// File: rtl/dma_flow_fsm.sv
module dma_flow_fsm
  import dma_chain_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          prio_grant,
  input  logic          bus_grant,
  input  logic          dst_req,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic [DW-1:0] src_addr,
  input  logic [DW-1:0] dst_addr,
  input  logic [DW-1:0] nxt_ptr,
  input  logic [CW-1:0] remain,
  input  logic          tc_ie,
  input  logic          to_periph,
  output logic          busy,
  output logic          prio_req,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  output logic          ld_we,
  output logic [1:0]    ld_sel,
  output logic          adv,
  output logic          tc_irq,
  output logic          err_irq,
  output logic          dst_ack
);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] fbase_q;
  logic [1:0]    fidx_q;
  logic          err_q;
  logic          fail;
  logic          rsp_ok;

  assign rsp_ok = mem_rsp_valid && !mem_rsp_err;

  always_comb begin
    state_d = state_q;
    ld_we   = 1'b0;
    adv     = 1'b0;
    fail    = 1'b0;
    case (state_q)
      S_IDLE:    if (start) state_d = S_ARB;
      S_ARB: begin
        if (remain == '0)                  state_d = S_TERM;
        else if (prio_grant && bus_grant)  state_d = S_RD_REQ;
      end
      S_RD_REQ:  if (mem_req_ready) state_d = S_RD_RSP;
      S_RD_RSP: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fail    = 1'b1;
            state_d = S_IDLE;
          end else begin
            state_d = to_periph ? S_WR_WAIT : S_WR_REQ;
          end
        end
      end
      S_WR_WAIT: if (dst_req) state_d = S_WR_REQ;
      S_WR_REQ:  if (mem_req_ready) state_d = S_WR_RSP;
      S_WR_RSP: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fail    = 1'b1;
            state_d = S_IDLE;
          end else begin
            adv     = 1'b1;
            state_d = (remain == CW'(1)) ? S_TERM : S_ARB;
          end
        end
      end
      S_TERM:    state_d = (nxt_ptr != '0) ? S_FT_REQ : S_IDLE;
      S_FT_REQ:  if (mem_req_ready) state_d = S_FT_RSP;
      S_FT_RSP: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fail    = 1'b1;
            state_d = S_IDLE;
          end else begin
            ld_we   = 1'b1;
            state_d = (fidx_q == 2'd3) ? S_ARB : S_FT_REQ;
          end
        end
      end
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hold_q  <= '0;
      fbase_q <= '0;
      fidx_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= fail;
      if (state_q == S_RD_RSP && rsp_ok) hold_q <= mem_rsp_rdata;
      if (state_q == S_TERM) begin
        fbase_q <= nxt_ptr;
        fidx_q  <= '0;
      end else if (state_q == S_FT_RSP && rsp_ok) begin
        fidx_q  <= fidx_q + 2'd1;
      end
    end
  end

  always_comb begin
    case (state_q)
      S_RD_REQ: mem_req_addr = src_addr;
      S_WR_REQ: mem_req_addr = dst_addr;
      S_FT_REQ: mem_req_addr = fbase_q + DW'({fidx_q, 2'b00});
      default:  mem_req_addr = '0;
    endcase
  end

  assign busy          = (state_q != S_IDLE);
  assign prio_req      = (state_q == S_ARB) && (remain != '0);
  assign mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ) || (state_q == S_FT_REQ);
  assign mem_req_write = (state_q == S_WR_REQ);
  assign mem_req_wdata = hold_q;
  assign ld_sel        = fidx_q;
  assign tc_irq        = (state_q == S_TERM) && tc_ie;
  assign dst_ack       = (state_q == S_TERM) && to_periph;
  assign err_irq       = err_q;

  // R2: a data read starts only after both grants were present
  a_r2_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD_REQ && $past(state_q) == S_ARB) |-> $past(prio_grant && bus_grant));

  // R5: a paced write starts only after the peripheral asked
  a_r5_paced_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR_REQ && $past(state_q) == S_WR_WAIT) |-> $past(dst_req));

  // R4: a stalled request holds its fields
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R6: terminal-count pulse lasts one cycle
  a_r6_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |=> !tc_irq);

  // R10: the two interrupts never coincide
  a_r10_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(tc_irq && err_irq));

  // R8: end of chain drops the enable
  a_r8_chain_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TERM && nxt_ptr == '0) |=> !busy);

  // R9: an error leaves the channel disabled
  a_r9_err_off: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !busy);

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          cfg_start,
  output logic          ch_enabled,
  output logic          prio_req,
  input  logic          prio_grant,
  input  logic          bus_grant,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic          mem_rsp_err,
  input  logic          dst_req,
  output logic          dst_ack,
  output logic          tc_irq,
  output logic          err_irq
);

  logic          busy;
  logic          ld_we;
  logic [1:0]    ld_sel;
  logic          adv;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] src_addr, dst_addr, nxt_ptr;
  logic [CW-1:0] remain;
  logic          tc_ie, to_periph;

  // setup writes count only while idle; descriptor loads only while busy
  assign wr_en   = (cfg_we && !busy) || ld_we;
  assign wr_sel  = ld_we ? ld_sel : cfg_sel;
  assign wr_data = ld_we ? mem_rsp_rdata : cfg_wdata;

  dma_desc_regs #(.DW(DW), .CW(CW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .adv       (adv),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .nxt_ptr   (nxt_ptr),
    .remain    (remain),
    .tc_ie     (tc_ie),
    .to_periph (to_periph)
  );

  dma_flow_fsm #(.DW(DW), .CW(CW)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (cfg_start),
    .prio_grant    (prio_grant),
    .bus_grant     (bus_grant),
    .dst_req       (dst_req),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rsp_rdata (mem_rsp_rdata),
    .src_addr      (src_addr),
    .dst_addr      (dst_addr),
    .nxt_ptr       (nxt_ptr),
    .remain        (remain),
    .tc_ie         (tc_ie),
    .to_periph     (to_periph),
    .busy          (busy),
    .prio_req      (prio_req),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .ld_we         (ld_we),
    .ld_sel        (ld_sel),
    .adv           (adv),
    .tc_irq        (tc_irq),
    .err_irq       (err_irq),
    .dst_ack       (dst_ack)
  );

  assign ch_enabled = busy;

  // R1: a start while idle enables the channel one cycle later
  a_r1_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start && !ch_enabled) |=> ch_enabled);

endmodule

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;

  logic        clk, rst_n;
  logic        cfg_we, cfg_start;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        ch_enabled, prio_req, prio_grant, bus_grant;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic        mem_rsp_valid, mem_rsp_err;
  logic        dst_req, dst_ack, tc_irq, err_irq;

  dma_chain_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_start(cfg_start), .ch_enabled(ch_enabled), .prio_req(prio_req),
    .prio_grant(prio_grant), .bus_grant(bus_grant), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err), .dst_req(dst_req), .dst_ack(dst_ack),
    .tc_irq(tc_irq), .err_irq(err_irq)
  );

  int nvec = 0, nfail = 0, cyc = 0, run_id = 0;
  logic [31:0] mem [256];
  bit pend, pend_err, err_en, per_mode, gtok, dtok, post, tc_prev, err_prev, stall_prev;
  logic [31:0] pend_data, err_addr, stall_addr;
  int tc_cnt, dack_cnt, err_cnt, post_req;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s run %0d: actual %h expected %h", req, run_id, act, exp);
    end
  endtask

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  // memory, grant and pacing model plus port monitors
  initial begin
    pend = 0; mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_rdata = '0;
    mem_req_ready = 0; prio_grant = 0; bus_grant = 0; dst_req = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = pend; mem_rsp_rdata = pend_data; mem_rsp_err = pend_err; pend = 0;
      mem_req_ready = (cyc % 3) != 1;
      prio_grant    = (cyc % 5) != 0;
      bus_grant     = (cyc % 7) != 3;
      dst_req       = per_mode && (cyc % 6 == 0);
      #1;
      if (stall_prev) chk(mem_req_valid && mem_req_addr == stall_addr, "R4", mem_req_addr, stall_addr);
      stall_prev = mem_req_valid && !mem_req_ready;
      stall_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend      = 1;
        pend_err  = err_en && mem_req_addr == err_addr;
        pend_data = mem[mem_req_addr[9:2]];
        if (mem_req_write) begin
          if (per_mode) chk(dtok, "R5", 32'(dtok), 1);
          dtok = 0;
          if (!pend_err) mem[mem_req_addr[9:2]] = mem_req_wdata;
        end else if (mem_req_addr >= 32'h100 && mem_req_addr < 32'h200) begin
          chk(gtok, "R2", 32'(gtok), 1);
          gtok = 0;
        end
      end
      if (post && mem_req_valid) post_req++;
      if (prio_req && prio_grant && bus_grant) gtok = 1;
      if (dst_req) dtok = 1;
      if (tc_irq && tc_prev) chk(0, "R10", 2, 1);
      if (err_irq && err_prev) chk(0, "R10", 2, 1);
      if (tc_irq && err_irq) chk(0, "R10", 3, 0);
      if (tc_irq) tc_cnt++;
      if (err_irq) err_cnt++;
      if (dst_ack) dack_cnt++;
      tc_prev = tc_irq; err_prev = err_irq;
    end
  end

  task automatic cfg_wr(input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] srcval(input int k, input int i);
    return run_id * 256 + 8 * k + i + 1;
  endfunction

  function automatic logic [31:0] ctrlw(input bit ie, input bit per, input int c);
    return {ie, per, 18'd0, 12'(c)};
  endfunction

  // ek: -1 none, 0 data read error, 1 descriptor read error, 2 data write error
  task automatic run(input int base, input int nd, input bit ie, input bit per, input int ek, input bit poke);
    int cnt[4];
    int copied[4];
    int done, t;
    logic [31:0] nx;
    run_id++;
    for (int k = 0; k < 4; k++) cnt[k] = (base + k) % 5;
    for (int w = 16; w < 256; w++) mem[w] = '0;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 8; i++) mem[64 + 8 * k + i] = srcval(k, i);
    for (int k = 1; k < nd; k++) begin
      mem[16 + 4 * k]     = 32'h100 + 32'(32 * k);
      mem[16 + 4 * k + 1] = 32'h200 + 32'(32 * k);
      mem[16 + 4 * k + 2] = (k + 1 < nd) ? 32'h040 + 32'(16 * (k + 1)) : 32'h0;
      mem[16 + 4 * k + 3] = ctrlw(ie, per, cnt[k]);
    end
    for (int k = 0; k < 4; k++) copied[k] = (k < nd) ? cnt[k] : 0;
    done = nd;
    err_en = ek >= 0;
    case (ek)
      0: begin err_addr = 32'h124; copied[1] = 1; done = 1; end
      1: begin err_addr = 32'h058; copied[1] = 0; done = 1; end
      2: begin err_addr = 32'h200; copied[0] = 0; done = 0; end
      default: err_addr = 32'hFFFF_FFFF;
    endcase
    for (int k = done + 1; k < 4; k++) copied[k] = 0;
    per_mode = per; gtok = 0; dtok = 0;
    tc_cnt = 0; dack_cnt = 0; err_cnt = 0;
    nx = (nd > 1) ? 32'h050 : 32'h0;
    cfg_wr(2'd0, 32'h100);
    cfg_wr(2'd1, 32'h200);
    cfg_wr(2'd2, nx);
    cfg_wr(2'd3, ctrlw(ie, per, cnt[0]));
    cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
    chk(ch_enabled, "R1", 32'(ch_enabled), 1);
    if (poke) begin
      // must be ignored while enabled
      cfg_wr(2'd0, 32'h3F0);
      cfg_wr(2'd1, 32'h3F0);
      cfg_wr(2'd2, 32'h0);
      cfg_wr(2'd3, 32'h0);
      cfg_start = 1;
      @(negedge clk);
      cfg_start = 0;
    end
    t = 0;
    while (ch_enabled && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(!ch_enabled, (ek >= 0) ? "R9" : "R8", 32'(ch_enabled), 0);
    post = 1; post_req = 0;
    repeat (4) @(negedge clk);
    post = 0;
    chk(post_req == 0, (ek >= 0) ? "R9" : "R8", 32'(post_req), 0);
    chk(tc_cnt == (ie ? done : 0), "R6", 32'(tc_cnt), 32'(ie ? done : 0));
    chk(dack_cnt == (per ? done : 0), "R5", 32'(dack_cnt), 32'(per ? done : 0));
    chk(err_cnt == ((ek >= 0) ? 1 : 0), "R9", 32'(err_cnt), 32'((ek >= 0) ? 1 : 0));
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 5; i++) begin
        logic [31:0] e;
        e = (i < copied[k]) ? srcval(k, i) : 32'h0;
        chk(mem[128 + 8 * k + i] == e, (k > 0) ? "R7" : "R3", mem[128 + 8 * k + i], e);
      end
    err_en = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_start = 0; cfg_sel = '0; cfg_wdata = '0;
    err_en = 0; per_mode = 0; post = 0; stall_prev = 0; tc_prev = 0; err_prev = 0;
    for (int w = 0; w < 256; w++) mem[w] = '0;
    repeat (4) @(negedge clk);
    chk(!ch_enabled, "R1", 32'(ch_enabled), 0);
    chk(!mem_req_valid, "R4", 32'(mem_req_valid), 0);
    chk(!tc_irq && !err_irq, "R10", {30'd0, tc_irq, err_irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // sweep counts 0..4, chain lengths, interrupt enable and pacing (R3 R6 R7 R8 R5)
    for (int base = 0; base < 4; base++)
      for (int nd = 1; nd <= 3; nd++)
        for (int ie = 0; ie < 2; ie++)
          for (int per = 0; per < 2; per++)
            run(base, nd, 1'(ie), 1'(per), -1, 0);
    // error on each kind of access (R9)
    for (int ek = 0; ek < 3; ek++)
      for (int ie = 0; ie < 2; ie++)
        for (int per = 0; per < 2; per++)
          run(3, 2, 1'(ie), 1'(per), ek, 0);
    // setup writes while enabled are ignored (R1)
    run(3, 3, 1, 0, -1, 1);
    run(3, 3, 1, 1, -1, 1);
    summary();
    $finish;
  end

endmodule